// File: doc/BRIEF.md
# Packet-to-Byte Receive Feeder

This block connects a fast packet source to a slow single-character receive register. The source writes a packet of 1 to 64 bytes into a local buffer through a valid/ready write port. The block then delivers those bytes downstream one at a time, in the order they were written. It pushes a byte only when the downstream receiver reports that it no longer holds an unread character.

While any byte of a packet remains undelivered, the write port is held off. This means the source can never overrun the slow receiver. A remaining-byte counter and a read offset track progress through the buffer. When the counter reaches zero the offset returns to the first buffer entry and intake reopens. After each push the block waits one clock, so that the downstream busy flag can reflect the new character before the next byte is considered.

Top module: `pkt_byte_feeder`

## Requirements
- R1: A packet holds 1 to 64 bytes. It ends on the byte written with `pkt_last` high, or on the 64th byte whichever comes first; a 64-byte packet without `pkt_last` delivers all 64 bytes.
- R2: `pkt_ready` is high only while the remaining-byte count is zero. A byte offered with `pkt_valid` high while `pkt_ready` is low is not stored and never appears on `rx_byte`.
- R3: For a one-byte packet with `rx_busy` low, `rx_push` is high in the clock cycle right after the write, and `pkt_ready` is high again in the following cycle.
- R4: `rx_push` is high only in a cycle in which `rx_busy` is low (`rx_busy` high means the downstream register still holds an unread character).
- R5: Each push lowers the remaining count by one and moves the read offset to the next buffer entry.
- R6: After the last byte of a packet is pushed, the read offset returns to entry 0, so the next packet is delivered starting with its own first byte.
- R7: Bytes appear on `rx_byte` with `rx_push` in the same order in which they were written.
- R8: At most one byte is pushed per clock, and no byte is pushed in the cycle that directly follows a push.
- R9: `pkt_ready` is low from the cycle after the last byte of a packet is accepted until the remaining count is back to zero.
- R10: Asserting `rst_n` low clears the remaining count and the read offset at once. `rx_push` is then low and `pkt_ready` is high, and the next packet starts at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| pkt_valid | input | 1 | Write port holds a byte |
| pkt_data | input | 8 | Byte being written |
| pkt_last | input | 1 | Marks the final byte of a packet |
| pkt_ready | output | 1 | Block can accept a byte this cycle |
| rx_push | output | 1 | `rx_byte` is handed to the downstream register this cycle |
| rx_byte | output | 8 | Byte delivered downstream |
| rx_busy | input | 1 | Downstream register still holds an unread character |

## Verification
The assertions assume that `rx_busy` reflects a pushed character from the clock after the push, and that it is held by a well-behaved receiver rather than toggled at random within a cycle. They also assume that the write port offers no byte mid-reset. The bench models the downstream register as a holder that raises busy on the edge of each push and keeps it for a configurable number of cycles. All inputs are driven on falling edges, and `pkt_valid` is lowered during reset. Stray writes offered while the block is draining are removed before the drain can end.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
  parameter int unsigned FEED_DEPTH  = 64;
  parameter int unsigned FEED_DATA_W = 8;
  localparam int unsigned FEED_IDX_W = $clog2(FEED_DEPTH);
  localparam int unsigned FEED_CNT_W = $clog2(FEED_DEPTH + 1);
endpackage

// File: rtl/feeder_store.sv
module feeder_store #(
  parameter int unsigned DEPTH  = feeder_pkg::FEED_DEPTH,
  parameter int unsigned DATA_W = feeder_pkg::FEED_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // one enabled register per entry, written only when addressed
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_addr == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (sel) mem_q[e] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/feeder_intake.sv
module feeder_intake #(
  parameter int unsigned DEPTH = feeder_pkg::FEED_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             pkt_last,
  input  logic             open,      // intake allowed (count is zero)
  output logic             accept,
  output logic [IDX_W-1:0] wr_idx,
  output logic             pkt_end,
  output logic [CNT_W-1:0] pkt_len
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_top;

  assign accept  = pkt_valid && open;
  assign at_top  = (idx_q == IDX_W'(DEPTH - 1));
  assign pkt_end = accept && (pkt_last || at_top);
  assign pkt_len = CNT_W'(idx_q) + CNT_W'(1);
  assign wr_idx  = idx_q;

  always_comb begin
    idx_d = idx_q;
    if (pkt_end)      idx_d = '0;
    else if (accept)  idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/feeder_pacer.sv
module feeder_pacer #(
  parameter int unsigned DEPTH = feeder_pkg::FEED_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  input  logic             busy,
  output logic             push,
  output logic             idle,
  output logic [CNT_W-1:0] remain,
  output logic [IDX_W-1:0] offset
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [IDX_W-1:0] off_q, off_d;
  logic             gap_q, gap_d;
  logic             last_one;

  assign idle     = (rem_q == '0);
  assign last_one = (rem_q == CNT_W'(1));
  // busy is looked at again after every push: one quiet cycle between pushes
  assign push     = !idle && !busy && !gap_q;
  assign gap_d    = push;

  always_comb begin
    rem_d = rem_q;
    off_d = off_q;
    if (load) begin
      rem_d = load_len;
      off_d = '0;
    end else if (push) begin
      rem_d = rem_q - CNT_W'(1);
      off_d = last_one ? '0 : off_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      off_q <= '0;
      gap_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      off_q <= off_d;
      gap_q <= gap_d;
    end
  end

  assign remain = rem_q;
  assign offset = off_q;
endmodule

// File: rtl/pkt_byte_feeder.sv
module pkt_byte_feeder #(
  parameter int unsigned DEPTH  = feeder_pkg::FEED_DEPTH,
  parameter int unsigned DATA_W = feeder_pkg::FEED_DATA_W,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [DATA_W-1:0] pkt_data,
  input  logic              pkt_last,
  output logic              pkt_ready,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_byte,
  input  logic              rx_busy
);
  logic             accept;
  logic             pkt_end;
  logic [IDX_W-1:0] wr_idx;
  logic [CNT_W-1:0] pkt_len;
  logic             idle;
  logic [CNT_W-1:0] rem_cnt;
  logic [IDX_W-1:0] rd_off;

  feeder_intake #(.DEPTH(DEPTH)) intake_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_valid(pkt_valid),
    .pkt_last (pkt_last),
    .open     (idle),
    .accept   (accept),
    .wr_idx   (wr_idx),
    .pkt_end  (pkt_end),
    .pkt_len  (pkt_len)
  );

  feeder_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk    (clk),
    .wr_en  (accept),
    .wr_addr(wr_idx),
    .wr_data(pkt_data),
    .rd_addr(rd_off),
    .rd_data(rx_byte)
  );

  feeder_pacer #(.DEPTH(DEPTH)) pacer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pkt_end),
    .load_len(pkt_len),
    .busy    (rx_busy),
    .push    (rx_push),
    .idle    (idle),
    .remain  (rem_cnt),
    .offset  (rd_off)
  );

  assign pkt_ready = idle;
endmodule

// File: rtl/feeder_chk.sv
module feeder_chk #(
  parameter int unsigned DEPTH = feeder_pkg::FEED_DEPTH,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             pkt_last,
  input logic             pkt_ready,
  input logic             rx_push,
  input logic             rx_busy,
  input logic [CNT_W-1:0] rem,
  input logic [IDX_W-1:0] off
);
  AST_PUSH_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_busy); // R4

  AST_PUSH_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push); // R8

  AST_NO_INTAKE_WHILE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !pkt_ready); // R2

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && pkt_last) |=> !pkt_ready); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (rem == $past(rem) - CNT_W'(1))); // R5

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= CNT_W'(DEPTH)); // R1

  AST_OFFSET_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> (off == '0)); // R6
endmodule

bind pkt_byte_feeder feeder_chk #(.DEPTH(DEPTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pkt_valid(pkt_valid),
  .pkt_last (pkt_last),
  .pkt_ready(pkt_ready),
  .rx_push  (rx_push),
  .rx_busy  (rx_busy),
  .rem      (rem_cnt),
  .off      (rd_off)
);

// File: tb/pkt_byte_feeder_tb.sv
module pkt_byte_feeder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_valid = 1'b0;
  logic [7:0] pkt_data = '0;
  logic       pkt_last = 1'b0;
  logic       pkt_ready;
  logic       rx_push;
  logic [7:0] rx_byte;
  logic       rx_busy;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;   // 50 MHz

  pkt_byte_feeder dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_last(pkt_last), .pkt_ready(pkt_ready), .rx_push(rx_push),
    .rx_byte(rx_byte), .rx_busy(rx_busy)
  );

  // downstream receiver model: holds a pushed character for hold_cfg cycles
  int hold_cfg = 0;
  int hold_left = 0;
  assign rx_busy = (hold_left != 0);
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hold_left <= 0;
    else if (rx_push && hold_cfg != 0)  hold_left <= hold_cfg;
    else if (hold_left != 0)            hold_left <= hold_left - 1;
  end

  // capture of delivered bytes, with per-push protocol checks
  logic [7:0] rx_log [64];
  int  rx_n = 0;
  logic prev_push = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_push) begin
      check(!rx_busy, "R4 push while busy", rx_busy, 0);
      check(!prev_push, "R8 back-to-back push", 1, 0);
      if (rx_n < 64) rx_log[rx_n] = rx_byte;
      rx_n = rx_n + 1;
    end
    prev_push = rst_n && rx_push;
  end

  // table: {length, downstream hold cycles, seed, use last flag}
  localparam int NVEC = 7;
  localparam logic [6:0] V_LEN  [NVEC] = '{7'd1, 7'd5, 7'd3, 7'd7, 7'd2, 7'd12, 7'd64};
  localparam logic [3:0] V_HOLD [NVEC] = '{4'd0, 4'd0, 4'd2, 4'd5, 4'd1, 4'd3, 4'd1};
  localparam logic [7:0] V_SEED [NVEC] = '{8'hA5, 8'h10, 8'h3C, 8'hF0, 8'h77, 8'h01, 8'h80};
  localparam bit         V_LAST [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic send_pkt(input int len, input logic [7:0] seed, input bit use_last);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      while (!pkt_ready) @(negedge clk);
      pkt_valid = 1'b1;
      pkt_data  = pat(seed, i);
      pkt_last  = use_last && (i == len - 1);
    end
    @(negedge clk);
    pkt_valid = 1'b0;
    pkt_last  = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!pkt_ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(pkt_ready, "R9 ready back after drain", pkt_ready, 1);
  endtask

  task automatic compare(input int len, input logic [7:0] seed, input string req);
    int bad = 0;
    check(rx_n == len, req, rx_n, len);
    for (int i = 0; i < len && i < 64; i++)
      if (rx_log[i] !== pat(seed, i)) bad++;
    check(bad == 0, "R7 byte order/content", bad, 0);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(pkt_ready == 1'b1, "R10 ready in reset", pkt_ready, 1);
    check(rx_push == 1'b0, "R10 no push in reset", rx_push, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      hold_cfg = int'(V_HOLD[v]);
      rx_n = 0;
      send_pkt(int'(V_LEN[v]), V_SEED[v], V_LAST[v]);
      // now one cycle after the final write edge
      check(!pkt_ready, "R9 ready low after last byte", pkt_ready, 0);
      if (V_LEN[v] == 7'd1 && V_HOLD[v] == 4'd0) begin
        check(rx_push, "R3 single byte pushed at once", rx_push, 1);
        @(negedge clk);
        check(pkt_ready, "R3 ready back next cycle", pkt_ready, 1);
      end
      wait_idle();
      compare(int'(V_LEN[v]), V_SEED[v],
              (V_LEN[v] == 7'd64) ? "R1 64-byte packet count" : "R5 delivered count");
    end

    // R2: writes offered while draining are ignored
    hold_cfg = 3;
    rx_n = 0;
    send_pkt(12, 8'h42, 1'b1);
    pkt_valid = 1'b1; pkt_last = 1'b1; pkt_data = 8'hEE;
    repeat (4) @(negedge clk);
    pkt_valid = 1'b0; pkt_last = 1'b0;
    wait_idle();
    compare(12, 8'h42, "R2 stray writes ignored");

    // R6: a shorter packet after a longer one starts at its own first byte
    hold_cfg = 0;
    rx_n = 0;
    send_pkt(2, 8'h90, 1'b1);
    wait_idle();
    compare(2, 8'h90, "R6 offset back to start");

    // R10: reset in the middle of a drain
    hold_cfg = 4;
    rx_n = 0;
    send_pkt(10, 8'h55, 1'b1);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(pkt_ready, "R10 ready after mid-drain reset", pkt_ready, 1);
    check(!rx_push, "R10 no push after reset", rx_push, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    hold_cfg = 1;
    rx_n = 0;
    send_pkt(3, 8'hC1, 1'b1);
    wait_idle();
    compare(3, 8'hC1, "R10 next packet from entry 0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule